// File: doc/BRIEF.md
# Parallel Camera Timing Generator

This block is a synthesizable stand-in for a parallel-output image sensor. Capture logic can then be exercised in simulation or on a board without a real sensor attached. A single start pulse begins a fixed number of frames, sent one after another. Each frame opens with a frame-sync pulse and a quiet porch, followed by a set number of lines. During each line, a line-valid strobe stays high while an 8-bit bus carries 16-bit RGB565 pixels, one byte per clock.

Every length is a parameter: pixels per line, lines per frame, frame-sync width, porch, gap between lines and frame count. The byte stream is a down-counting pattern. A receiver, or a bench, can therefore predict every byte. To make that easy, the current line number and the byte position inside the line are also brought out. A done flag reports the end of the whole sequence.

Top module: `cam_stream_gen`

## Requirements
- R1: While rst_n is low, vsync, hsync, data, line_idx, beat_idx and done are all 0, and the generator is idle.
- R2: A start pulse sampled while idle makes vsync high from the next cycle for exactly SYNC_LEN (default 10) cycles. hsync is never high while vsync is high.
- R3: After vsync falls, vsync and hsync both stay low for exactly PORCH_LEN (default 20) cycles before the first line.
- R4: Each line holds hsync high for exactly 2*LINE_PIXELS consecutive cycles, one byte per cycle. Every line, including the last of a frame, is followed by GAP_LEN (default 20) cycles with hsync low. A frame has ROWS lines.
- R5: The first byte sent after a start is FIRST_BYTE (default 0xFF), and every later byte is the previous one minus 1 modulo 256. The count carries across lines and frames. Beats 2p and 2p+1 of a line are the upper and lower byte of pixel p.
- R6: data changes only in cycles where hsync is high. Otherwise it keeps the last byte sent (0 after reset).
- R7: line_idx is the 0-based line number during a line and its following gap, and 0 during vsync and porch. beat_idx is the 0-based byte position while hsync is high, and 0 otherwise.
- R8: FRAMES (default 15) frames are sent. Each later frame's vsync starts in the cycle right after the previous frame's last gap.
- R9: done rises in the cycle after the last gap of the last frame. It then stays high, with vsync and hsync low and data unchanged, until the next accepted start.
- R10: A start pulse that arrives while the sequence is running, including on the final gap cycle, has no effect.
- R11: A start while done is high restarts the sequence. done falls in the same cycle that vsync rises, and the byte pattern restarts at FIRST_BYTE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one byte per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin the frame sequence |
| vsync | output | 1 | Frame-sync pulse, active high |
| hsync | output | 1 | Line-valid strobe, active high |
| data | output | 8 | Pixel byte bus |
| line_idx | output | ROW_W | Current line number within the frame |
| beat_idx | output | BEAT_W | Byte position within the current line |
| done | output | 1 | Sequence finished |

## Verification
Two events can share a cycle at the end of the run: a start request and the expiry of the final gap, which raises done. The bench drives start on exactly that gap cycle. It then expects the generator to drop to idle with done high, rather than begin a new frame. A second start, placed in the middle of a line, must leave the byte stream and the line timing undisturbed. The byte count crosses zero inside a run, so the modulo-256 wrap and its carry into the next frame are judged against the bench's own down-counter.

// File: rtl/camgen_pkg.sv
package camgen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SYNC  = 3'd1,
    PH_PORCH = 3'd2,
    PH_LINE  = 3'd3,
    PH_GAP   = 3'd4
  } phase_t;

  function automatic logic [7:0] step_byte(input logic [7:0] cur);
    return cur - 8'd1;
  endfunction

  function automatic int beats_of(input int pixels);
    return 2 * pixels;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int width_for(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/camgen_phase_timer.sv
module camgen_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             at_end
);

  assign at_end = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));

endmodule

// File: rtl/camgen_byte_src.sv
module camgen_byte_src
  import camgen_pkg::*;
#(
  parameter logic [7:0] FIRST_BYTE = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reload,
  input  logic       emit,
  output logic [7:0] data
);

  logic [7:0] pat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= FIRST_BYTE;
      data  <= 8'd0;
    end else if (reload) begin
      pat_q <= FIRST_BYTE;
    end else if (emit) begin
      data  <= pat_q;
      pat_q <= step_byte(pat_q);
    end
  end

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> $stable(data));

endmodule

// File: rtl/cam_stream_gen.sv
module cam_stream_gen
  import camgen_pkg::*;
#(
  parameter int         LINE_PIXELS = 800,
  parameter int         ROWS        = 480,
  parameter int         SYNC_LEN    = 10,
  parameter int         PORCH_LEN   = 20,
  parameter int         GAP_LEN     = 20,
  parameter int         FRAMES      = 15,
  parameter logic [7:0] FIRST_BYTE  = 8'hFF,
  localparam int        BEATS       = beats_of(LINE_PIXELS),
  localparam int        ROW_W       = width_for(ROWS),
  localparam int        BEAT_W      = width_for(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              vsync,
  output logic              hsync,
  output logic [7:0]        data,
  output logic [ROW_W-1:0]  line_idx,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              done
);

  localparam int CNT_W   = width_for(max4(SYNC_LEN, PORCH_LEN, BEATS, GAP_LEN) + 1);
  localparam int FRAME_W = width_for(FRAMES);
  localparam logic [CNT_W-1:0]   LIM_SYNC  = CNT_W'(SYNC_LEN - 1);
  localparam logic [CNT_W-1:0]   LIM_PORCH = CNT_W'(PORCH_LEN - 1);
  localparam logic [CNT_W-1:0]   LIM_LINE  = CNT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0]   LIM_GAP   = CNT_W'(GAP_LEN - 1);
  localparam logic [ROW_W-1:0]   ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [FRAME_W-1:0] FRM_LAST  = FRAME_W'(FRAMES - 1);

  phase_t             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt, limit;
  logic               phase_end;
  logic [ROW_W-1:0]   row_q;
  logic [FRAME_W-1:0] frame_q;

  // named events
  logic start_ok, row_last, frame_last, seq_end, emit;

  assign start_ok   = start && (phase_q == PH_IDLE);
  assign row_last   = (row_q == ROW_LAST);
  assign frame_last = (frame_q == FRM_LAST);
  assign seq_end    = (phase_q == PH_GAP) && phase_end && row_last && frame_last;
  assign emit       = (phase_d == PH_LINE);

  always_comb begin
    case (phase_q)
      PH_SYNC:  limit = LIM_SYNC;
      PH_PORCH: limit = LIM_PORCH;
      PH_LINE:  limit = LIM_LINE;
      PH_GAP:   limit = LIM_GAP;
      default:  limit = '0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (start_ok)  phase_d = PH_SYNC;
      PH_SYNC:  if (phase_end) phase_d = PH_PORCH;
      PH_PORCH: if (phase_end) phase_d = PH_LINE;
      PH_LINE:  if (phase_end) phase_d = PH_GAP;
      PH_GAP:   if (phase_end) begin
        if (!row_last)        phase_d = PH_LINE;
        else if (!frame_last) phase_d = PH_SYNC;
        else                  phase_d = PH_IDLE;
      end
      default:  phase_d = PH_IDLE;
    endcase
  end

  camgen_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_ok || phase_end),
    .run    (phase_q != PH_IDLE),
    .limit  (limit),
    .cnt    (cnt),
    .at_end (phase_end)
  );

  camgen_byte_src #(.FIRST_BYTE(FIRST_BYTE)) u_bytes (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (start_ok),
    .emit   (emit),
    .data   (data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      frame_q <= '0;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (start_ok) begin
        row_q   <= '0;
        frame_q <= '0;
        done    <= 1'b0;
      end else if ((phase_q == PH_GAP) && phase_end) begin
        if (!row_last) begin
          row_q <= row_q + 1'b1;
        end else if (!frame_last) begin
          row_q   <= '0;
          frame_q <= frame_q + 1'b1;
        end
      end
      if (seq_end) done <= 1'b1;
    end
  end

  assign vsync    = (phase_q == PH_SYNC);
  assign hsync    = (phase_q == PH_LINE);
  assign line_idx = (phase_q == PH_LINE || phase_q == PH_GAP) ? row_q : '0;
  assign beat_idx = hsync ? cnt[BEAT_W-1:0] : '0;

  // R2
  sync_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> !hsync);

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && $past(hsync)) |-> (data == $past(data) - 8'd1));

  // R7
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && $past(hsync)) |-> (beat_idx == $past(beat_idx) + 1'b1));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vsync && !hsync));

  // R10
  late_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && start) |=> (done && !vsync));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (vsync && !done));

endmodule

// File: tb/tb_cam_stream_gen.sv
module tb_cam_stream_gen;

  localparam int PX = 30, ROWS = 5, FRAMES = 2;
  localparam int SYNC = 10, PORCH = 20, GAP = 20;
  localparam int BEATS = 2 * PX;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic       vsync, hsync, done;
  logic [7:0] data;
  logic [2:0] line_idx;
  logic [5:0] beat_idx;

  int n_run = 0, n_fail = 0;
  logic [7:0] pat_m = 8'hFF, last_m = 8'h00;

  always #2 clk = ~clk;

  cam_stream_gen #(.LINE_PIXELS(PX), .ROWS(ROWS), .SYNC_LEN(SYNC),
                   .PORCH_LEN(PORCH), .GAP_LEN(GAP), .FRAMES(FRAMES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vsync(vsync), .hsync(hsync),
    .data(data), .line_idx(line_idx), .beat_idx(beat_idx), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic cyc(input bit ev, input bit eh, input logic [7:0] ed,
                     input int el, input int eb, input bit edn, input string req);
    chk(vsync == ev, {req, " vsync"}, vsync, ev);
    chk(hsync == eh, {req, " hsync"}, hsync, eh);
    chk(data == ed, eh ? "R5 data" : "R6 data", data, ed);
    chk(int'(line_idx) == el, "R7 line_idx", line_idx, el);
    chk(int'(beat_idx) == eb, "R7 beat_idx", beat_idx, eb);
    chk(done == edn, "R9 done", done, edn);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic walk(input bit poke, input string first_req);
    for (int f = 0; f < FRAMES; f++) begin
      for (int c = 0; c < SYNC; c++) begin
        cyc(1, 0, last_m, 0, 0, 0, (f == 0 && c == 0) ? first_req : (f == 0 ? "R2" : "R8"));
        @(negedge clk);
      end
      for (int c = 0; c < PORCH; c++) begin
        cyc(0, 0, last_m, 0, 0, 0, "R3");
        @(negedge clk);
      end
      for (int r = 0; r < ROWS; r++) begin
        for (int b = 0; b < BEATS; b++) begin
          last_m = pat_m;
          pat_m  = pat_m - 8'd1;
          cyc(0, 1, last_m, r, b, 0, "R4");
          start = poke && f == 0 && r == 1 && b == 3;
          @(negedge clk);
          start = 1'b0;
        end
        for (int g = 0; g < GAP; g++) begin
          cyc(0, 0, last_m, r, 0, 0, "R4");
          start = poke && f == FRAMES - 1 && r == ROWS - 1 && g == GAP - 1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!vsync && !hsync && !done, "R1 controls", {vsync, hsync, done}, 0);
    chk(data == 8'h00, "R1 data", data, 0);
    chk(line_idx == 0 && beat_idx == 0, "R1 indices", {line_idx, beat_idx}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!vsync && !hsync && !done, "R1 idle after release", {vsync, hsync, done}, 0);
  endtask

  task automatic t_full_run();
    pulse_start();
    walk(1'b1, "R2");
  endtask

  task automatic t_end_state();
    chk(done == 1'b1, "R10 late start ignored, done", done, 1);
    for (int k = 0; k < 6; k++) begin
      chk(!vsync && !hsync, "R9 quiet", {vsync, hsync}, 0);
      chk(done == 1'b1, "R9 done held", done, 1);
      chk(data == last_m, "R9 data held", data, last_m);
      @(negedge clk);
    end
  endtask

  task automatic t_restart();
    pat_m = 8'hFF;
    pulse_start();
    chk(done == 1'b0 && vsync == 1'b1, "R11 done cleared with vsync", {done, vsync}, 1);
    walk(1'b0, "R11");
    chk(done == 1'b1, "R11 second run done", done, 1);
  endtask

  initial begin
    t_reset();
    t_full_run();
    t_end_state();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule